// File: doc/BRIEF.md
# Prioritized Multi-CPU Interrupt Controller

This block gathers 64 interrupt vectors into one pending register. Software raises bits through a set register and drops them through a clear register. Hardware sources such as the timer, error detectors and device lines can raise bits directly with a one-cycle pulse. The pending state can be read back but not written directly.

Each CPU, up to four, owns a 64-bit mask. For every CPU, the pending bits that its mask lets through are split into five fixed priority levels by bit range. Each level drives a separate interrupt pin to that CPU. A global enable input can hold every pin low without losing any pending state.

A masked-status read port returns the pending bits filtered by the mask of the CPU named on a select input.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the pending register, every mask and every level pin are zero.
- R2: A write to offset 0x20 ORs the write data into the pending register. The new value is visible on the read port in the cycle after the write edge.
- R3: A write to offset 0x28 clears every pending bit whose write-data bit is 1. All other bits are left unchanged.
- R4: A 1 on `hw_irq_i` for one cycle sets that pending bit. This also holds when a clear write to the same bit happens in the same cycle: the bit stays set.
- R5: The mask of CPU c is written and read at offset 8*c, for c in 0..NUM_CPU-1. Writing one CPU's mask leaves the other masks unchanged.
- R6: Pin `lvl_irq_o[5*c+l]` is the OR of (pending AND mask of CPU c) over the bit range of level l. The pin is registered, so it follows a change of pending or mask one clock later. The level ranges are:
  - level 0: bits 15..0
  - level 1: bits 31..16
  - level 2: bits 49..32
  - level 3: bit 50
  - level 4: bits 63..51
- R7: While `irq_en_i` is low, every level pin goes low at the next clock. The pending register does not change while no set, clear or hardware pulse occurs.
- R8: Offset 0x30 reads the pending register. Writes to 0x30 and 0x38 change no state.
- R9: Offset 0x38 reads the pending bits ANDed with the mask of the CPU given by `cpu_sel_i`. It reads zero when `cpu_sel_i` is not below NUM_CPU.
- R10: Reads of offsets 0x20, 0x28 and of any offset with no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i` (combinational) |
| cpu_sel_i | input | SEL_W | CPU whose mask filters the masked-status read |
| hw_irq_i | input | 64 | Hardware pulses that set pending bits |
| irq_en_i | input | 1 | Global enable for all level pins |
| lvl_irq_o | output | 5*NUM_CPU | Level pins; bit 5*c+l is level l of CPU c |

## Verification
A write or hardware pulse at clock edge k appears on the combinational read port right after edge k. The level pins follow one edge later, at k+1. A change of `irq_en_i` reaches the pins at the first edge after the change. The bench drives inputs on the falling edge. It reads registers shortly after that falling edge, before the next rising edge. It samples pins only after one extra rising edge has passed since the last state change. A sweep sets each of the 64 vectors alone under a rotating CPU mask and compares all twenty pins with level ranges computed in the bench.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int VEC_W   = 64;
  localparam int NUM_LVL = 5;

  localparam logic [7:0] OFS_SET  = 8'h20;
  localparam logic [7:0] OFS_CLR  = 8'h28;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_MSTS = 8'h38;

  function automatic int lvl_lo(int l);
    case (l)
      0: return 0;
      1: return 16;
      2: return 32;
      3: return 50;
      default: return 51;
    endcase
  endfunction

  function automatic int lvl_hi(int l);
    case (l)
      0: return 15;
      1: return 31;
      2: return 49;
      3: return 50;
      default: return 63;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] lvl_mask(int l);
    logic [VEC_W-1:0] m;
    m = '0;
    for (int i = 0; i < VEC_W; i++)
      if (i >= lvl_lo(l) && i <= lvl_hi(l)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_prio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic [VEC_W-1:0] hw_i,
  output logic [VEC_W-1:0] pend_o
);
  logic [VEC_W-1:0] pend_q, set_v, clr_v;

  assign set_v = set_en_i ? wdata_i : '0;
  assign clr_v = clr_en_i ? wdata_i : '0;

  // hardware pulse wins over clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= ((pend_q | set_v) & ~clr_v) | hw_i;

  assign pend_o = pend_q;

  // R2
  set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((pend_q & $past(wdata_i)) == $past(wdata_i)));
  // R3
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((pend_q & $past(wdata_i & ~hw_i)) == '0));
  // R4
  hw_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_i != '0) |=> ((pend_q & $past(hw_i)) == $past(hw_i)));
  // R7
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_en_i && !clr_en_i && hw_i == '0) |=> $stable(pend_q));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_prio_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [VEC_W-1:0]             wdata_i,
  output logic [NUM_CPU-1:0][VEC_W-1:0] mask_o
);
  logic [NUM_CPU-1:0][VEC_W-1:0] mask_q;
  logic [NUM_CPU-1:0]            hit;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign hit[c] = wr_en_i && (addr_i == ADDR_W'(c * 8));

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)     mask_q[c] <= '0;
      else if (hit[c]) mask_q[c] <= wdata_i;

    // R5
    mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && addr_i == ADDR_W'(c * 8)) |=> $stable(mask_q[c]));
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_prio_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int PIN_W = NUM_CPU * NUM_LVL
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [VEC_W-1:0]              pend_i,
  input  logic [NUM_CPU-1:0][VEC_W-1:0] mask_i,
  output logic [PIN_W-1:0]              lvl_o
);
  logic [PIN_W-1:0] lvl_d, lvl_q;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      localparam logic [VEC_W-1:0] LMASK = lvl_mask(l);
      assign lvl_d[c*NUM_LVL+l] = |(pend_i & mask_i[c] & LMASK);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= en_i ? lvl_d : '0;

  assign lvl_o = lvl_q;

  // R7
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (lvl_q == '0));
  // R6
  no_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> (lvl_q == '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 8,
  localparam int SEL_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int PIN_W  = NUM_CPU * NUM_LVL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VEC_W-1:0]  wdata_i,
  output logic [VEC_W-1:0]  rdata_o,
  input  logic [SEL_W-1:0]  cpu_sel_i,
  input  logic [VEC_W-1:0]  hw_irq_i,
  input  logic              irq_en_i,
  output logic [PIN_W-1:0]  lvl_irq_o
);
  logic                          set_en, clr_en;
  logic [VEC_W-1:0]              pend;
  logic [NUM_CPU-1:0][VEC_W-1:0] mask;

  assign set_en = wr_en_i && (addr_i == ADDR_W'(OFS_SET));
  assign clr_en = wr_en_i && (addr_i == ADDR_W'(OFS_CLR));

  irq_pend_reg u_pend (
    .clk_i, .rst_ni,
    .set_en_i(set_en), .clr_en_i(clr_en),
    .wdata_i, .hw_i(hw_irq_i), .pend_o(pend)
  );

  irq_mask_bank #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_mask (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .mask_o(mask)
  );

  irq_level_map #(.NUM_CPU(NUM_CPU)) u_lvl (
    .clk_i, .rst_ni, .en_i(irq_en_i),
    .pend_i(pend), .mask_i(mask), .lvl_o(lvl_irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (addr_i == ADDR_W'(c * 8)) rdata_o = mask[c];
    if (addr_i == ADDR_W'(OFS_STAT)) rdata_o = pend;
    if (addr_i == ADDR_W'(OFS_MSTS))
      for (int c = 0; c < NUM_CPU; c++)
        if (32'(cpu_sel_i) == c) rdata_o = pend & mask[c];
  end

  // R8
  stat_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFS_STAT) && hw_irq_i == '0) |=> $stable(pend));
  // R10
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_SET) || addr_i == ADDR_W'(OFS_CLR)) |-> (rdata_o == '0));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  localparam int NC = 4;
  localparam int NP = NC * 5;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, en = 1;
  logic [7:0] addr = 8'h40;
  logic [63:0] wdata = '0, hw = '0, rdata;
  logic [1:0] sel = '0;
  logic [NP-1:0] pins;

  int checks = 0, fails = 0;
  logic [63:0] m_pend;
  logic [63:0] m_mask [NC];

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NUM_CPU(NC), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cpu_sel_i(sel),
    .hw_irq_i(hw), .irq_en_i(en), .lvl_irq_o(pins)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int lvl_of(int v);
    if (v < 16) return 0;
    if (v < 32) return 1;
    if (v < 50) return 2;
    if (v == 50) return 3;
    return 4;
  endfunction

  function automatic logic [NP-1:0] exp_pins();
    logic [NP-1:0] p = '0;
    for (int c = 0; c < NC; c++)
      for (int v = 0; v < 64; v++)
        if (m_pend[v] && m_mask[c][v]) p[c*5 + lvl_of(v)] = 1'b1;
    return en ? p : '0;
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (a == 8'h20) m_pend = m_pend | d;
    else if (a == 8'h28) m_pend = m_pend & ~d;
    else if (a < 8'h20 && a[2:0] == 0) m_mask[a[4:3]] = d;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [63:0] exp, input string req);
    @(negedge clk);
    addr = a; #1;
    chk(rdata === exp, req, rdata, exp);
  endtask

  task automatic pins_chk(input string req);
    logic [NP-1:0] e;
    @(posedge clk); #1;
    e = exp_pins();
    chk(pins === e, req, 64'(pins), 64'(e));
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_pend = '0;
    for (int c = 0; c < NC; c++) m_mask[c] = '0;
    #12;
    chk(pins === '0, "R1 pins at reset", 64'(pins), 0);
    rst_n = 1;
    rd_chk(8'h30, 64'h0, "R1 pending at reset");
    for (int c = 0; c < NC; c++) rd_chk(8'(c*8), 64'h0, "R1 mask at reset");

    // R2/R6 sweep: one vector at a time, rotating the enabled CPU
    for (int v = 0; v < 64; v++) begin
      bus_wr(8'h28, '1);
      for (int c = 0; c < NC; c++)
        bus_wr(8'(c*8), (c == v % NC) ? '1 : 64'h0);
      bus_wr(8'h20, 64'h1 << v);
      rd_chk(8'h30, m_pend, "R2 set single vector");
      pins_chk("R6 level pin sweep");
      sel = 2'(v % NC);
      rd_chk(8'h38, m_pend, "R9 masked status own cpu");
      sel = 2'((v + 1) % NC);
      rd_chk(8'h38, 64'h0, "R9 masked status other cpu");
    end

    // R2 OR accumulation
    bus_wr(8'h28, '1);
    bus_wr(8'h20, 64'h00F0_0000_0000_000F);
    bus_wr(8'h20, 64'h8000_0001_0000_0000);
    rd_chk(8'h30, 64'h80F0_0001_0000_000F, "R2 or accumulate");

    // R3 selective clear
    bus_wr(8'h28, 64'h0000_0001_0000_0003);
    rd_chk(8'h30, 64'h80F0_0000_0000_000C, "R3 selective clear");

    // R5 mask isolation and readback
    bus_wr(8'h00, 64'h0000_0000_0000_FFFF);
    bus_wr(8'h08, 64'hFFFF_0000_0000_0000);
    bus_wr(8'h10, 64'h0004_0000_0000_0000);
    bus_wr(8'h18, 64'h00F0_0000_0000_0000);
    for (int c = 0; c < NC; c++) rd_chk(8'(c*8), m_mask[c], "R5 mask readback");
    pins_chk("R6 mixed masks");
    sel = 2'd1;
    rd_chk(8'h38, m_pend & m_mask[1], "R9 masked status cpu1");

    // R4 hardware pulse wins over clear
    @(negedge clk);
    wr_en = 1; addr = 8'h28; wdata = '1; hw = 64'h0004_0000_0000_0020;
    @(posedge clk); #1;
    wr_en = 0; hw = '0;
    m_pend = 64'h0004_0000_0000_0020;
    rd_chk(8'h30, m_pend, "R4 hw beats clear");
    pins_chk("R6 level3 from hw");
    @(negedge clk); hw = 64'h0000_0100_0000_0000;
    @(posedge clk); #1; hw = '0;
    m_pend = m_pend | 64'h0000_0100_0000_0000;
    rd_chk(8'h30, m_pend, "R4 hw pulse sets");

    // R7 enable gating with held pending
    bus_wr(8'h20, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_wr(8'h00, '1);
    @(negedge clk); en = 0;
    pins_chk("R7 pins gated");
    chk(pins === '0, "R7 all low", 64'(pins), 0);
    repeat (3) @(posedge clk);
    rd_chk(8'h30, m_pend, "R7 pending held");
    @(negedge clk); en = 1;
    pins_chk("R7 pins restored");

    // R8 read-only status and masked status
    bus_wr(8'h30, 64'h0);
    bus_wr(8'h38, 64'h0);
    rd_chk(8'h30, m_pend, "R8 status write ignored");
    for (int c = 0; c < NC; c++) rd_chk(8'(c*8), m_mask[c], "R8 masks untouched");

    // R10 write-only and unmapped reads
    rd_chk(8'h20, 64'h0, "R10 set reads zero");
    rd_chk(8'h28, 64'h0, "R10 clear reads zero");
    rd_chk(8'h40, 64'h0, "R10 unmapped zero");
    rd_chk(8'hF8, 64'h0, "R10 unmapped zero high");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule